// File: doc/BRIEF.md
# Challenge-Response Debug Access Gate

This block stands between an external debug port and the on-chip scan and debug chains. It holds the chain enable low until a debug tool proves that it knows a provisioned 64-bit shared secret. The tool raises a request and the gate presents a 32-bit challenge taken from a free-running LFSR. The tool returns a 32-bit response. The gate computes its own expected value from the secret and the challenge, compares the two, and opens the chains only on a match.

A lifecycle register sets the policy. Its value is loaded from a boot input during reset, and afterwards it can only move forward through development, production, user and end-of-life. In development the chains are open and no exchange takes place. In production and user the exchange is enforced. In end-of-life the chains stay shut for good. The secret can be written only while the lifecycle is in development, and no port reads it back. After three wrong responses in a row, the gate refuses all further requests until the next reset.

Top module: `dbg_auth_gate`

## Requirements
- R1: While reset is low, the lifecycle register loads `lc_boot`. After reset with a boot state of production or user, `chain_en`, `chal_valid` and `auth_done` are low and `lc_state` equals the boot value.
- R2: In production or user, when not locked out and no exchange is pending, a `dbg_req` sampled at a clock edge raises `chal_valid` after that edge and presents the challenge on `chal`. Two consecutive challenges are never equal.
- R3: The expected response starts from x = challenge and applies ROUNDS rounds (default 8), with i = 0 to ROUNDS-1: k = secret[31:0] for even i and secret[63:32] for odd i, t = x ^ k, then x = rotate-left(t, 5) + k + i, all modulo 2^32. A matching response raises `auth_ok` and opens `chain_en`.
- R4: `auth_done` is a one-cycle pulse. It appears exactly ROUNDS+1 clock edges after the edge that samples `resp_valid`, whether the response is right or wrong.
- R5: Each challenge admits one response. `chal_valid` drops when the response is taken. A `resp_valid` with no challenge pending produces no `auth_done`.
- R6: Three wrong results in a row lock out requests until reset. A correct result clears the count of wrong results.
- R7: Lifecycle encoding: 0 is development, 1 production, 2 user, 3 end-of-life. In development `chain_en` is high without any exchange, and requests raise no challenge.
- R8: In end-of-life `chain_en` is always low and requests raise no challenge.
- R9: A lifecycle advance request (`lc_adv_valid` with `lc_adv_state`) takes effect only if the requested state is numerically greater than the current one. Backward or equal requests leave `lc_state` unchanged.
- R10: An accepted lifecycle advance clears the unlock and abandons any pending exchange. `chain_en` and `chal_valid` are low after that edge.
- R11: `prov_we` loads `prov_secret` only in development. Writes in other states do not change the secret that responses are checked against.
- R12: A wrong response clears a previous unlock, so `chain_en` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lc_boot | input | 2 | Lifecycle value loaded during reset |
| lc_adv_valid | input | 1 | Lifecycle advance request strobe |
| lc_adv_state | input | 2 | Requested lifecycle state |
| lc_state | output | 2 | Current lifecycle state |
| prov_we | input | 1 | Secret write strobe (development only) |
| prov_secret | input | 64 | Secret value to store |
| dbg_req | input | 1 | Debug tool asks for a challenge |
| chal_valid | output | 1 | Challenge pending, awaiting a response |
| chal | output | 32 | Challenge value |
| resp_valid | input | 1 | Response strobe |
| resp | input | 32 | Tool response |
| auth_done | output | 1 | One-cycle pulse when a check completes |
| auth_ok | output | 1 | Valid with auth_done: response matched |
| chain_en | output | 1 | Opens the debug chains |

## Verification
The lockout after three wrong results in a row is the hardest state to reach. Random stimulus makes about one response in four wrong, so a run of three misses is rare. The bench therefore also drives a directed sequence of two misses, a hit, and then three misses. This proves that a hit clears the count and that only the third consecutive miss locks requests out. A lifecycle advance that lands while a challenge is pending is also forced on purpose, to show that the exchange is dropped.

// File: rtl/dag_pkg.sv
// Shared types and the keyed mixing round for the debug access gate.
// Assumes a 32-bit challenge/response and a 64-bit secret split in two words.
package dag_pkg;
    localparam int RESP_W = 32;
    localparam int KEY_W  = 64;

    typedef enum logic [1:0] {
        LC_DEV  = 2'd0,
        LC_PROD = 2'd1,
        LC_USER = 2'd2,
        LC_EOL  = 2'd3
    } lc_t;

    // One XOR-rotate-add round; the key word alternates with the round index.
    function automatic logic [RESP_W-1:0] mix_round(
        input logic [RESP_W-1:0] x,
        input logic [KEY_W-1:0]  key,
        input logic [RESP_W-1:0] idx
    );
        logic [RESP_W-1:0] k;
        logic [RESP_W-1:0] t;
        k = idx[0] ? key[KEY_W-1:RESP_W] : key[RESP_W-1:0];
        t = x ^ k;
        return {t[RESP_W-6:0], t[RESP_W-1:RESP_W-5]} + k + idx;
    endfunction
endpackage

// File: rtl/dag_lfsr.sv
// Free-running Galois LFSR supplying challenge values.
// Assumes SEED is nonzero; the tap set keeps the state nonzero forever.
module dag_lfsr #(
    parameter int          W    = 32,
    parameter logic [31:0] TAPS = 32'h8020_0003,
    parameter logic [31:0] SEED = 32'h1D0C_5A3B
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Advance one step every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED[W-1:0];
        else if (state[0])
            state <= (state >> 1) ^ TAPS[W-1:0];
        else
            state <= state >> 1;
    end
endmodule

// File: rtl/dag_mixer.sv
// Sequential keyed mixer: one round per cycle, ROUNDS rounds per run.
// A start pulse loads the seed; fin pulses the cycle after the last round.
// Assumes start is not raised again while a result is still wanted.
module dag_mixer
    import dag_pkg::*;
#(
    parameter int ROUNDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [RESP_W-1:0] seed,
    input  logic [KEY_W-1:0]  key,
    output logic [RESP_W-1:0] acc,
    output logic              fin
);
    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    logic [CNT_W-1:0] cnt;
    logic             run;

    // Load on start, then apply one round per cycle until the last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                acc <= seed;
                cnt <= '0;
                run <= 1'b1;
            end else if (run) begin
                acc <= mix_round(acc, key, RESP_W'(cnt));
                cnt <= cnt + CNT_W'(1);
                if (cnt == LAST) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/dag_lifecycle.sv
// One-way lifecycle register: loaded from the boot value in reset,
// afterwards only strictly forward moves are accepted.
module dag_lifecycle
    import dag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] boot,
    input  logic       adv_valid,
    input  logic [1:0] adv_state,
    output lc_t        lc,
    output logic       bump
);
    // An advance is accepted only if it moves forward.
    assign bump = adv_valid && (adv_state > lc);

    // Hold the state; take forward moves.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lc <= lc_t'(boot);
        else if (bump)
            lc <= lc_t'(adv_state);
    end
endmodule

// File: rtl/dbg_auth_gate.sv
// Challenge-response gate for the debug chains.
// Sequence: request -> challenge pending -> response taken -> mixer runs
// ROUNDS cycles -> compare and report. Lifecycle sets the policy: open in
// development, enforced in production/user, shut in end-of-life.
// Assumes the secret store keeps its value across reset (provisioned store).
module dbg_auth_gate
    import dag_pkg::*;
#(
    parameter int ROUNDS    = 8,
    parameter int MAX_FAILS = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  lc_boot,
    input  logic        lc_adv_valid,
    input  logic [1:0]  lc_adv_state,
    output logic [1:0]  lc_state,
    input  logic        prov_we,
    input  logic [63:0] prov_secret,
    input  logic        dbg_req,
    output logic        chal_valid,
    output logic [31:0] chal,
    input  logic        resp_valid,
    input  logic [31:0] resp,
    output logic        auth_done,
    output logic        auth_ok,
    output logic        chain_en
);
    localparam int FAIL_W = $clog2(MAX_FAILS + 1);

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_MIX} st_t;

    st_t               st;
    lc_t               lc;
    logic              bump;
    logic [RESP_W-1:0] lfsr_q;
    logic [RESP_W-1:0] chal_q;
    logic [RESP_W-1:0] resp_q;
    logic [RESP_W-1:0] expect_q;
    logic [KEY_W-1:0]  secret;
    logic              mix_fin;
    logic              mix_start;
    logic              unlock;
    logic [FAIL_W-1:0] fail_cnt;
    logic              locked;
    logic              enforced;

    dag_lifecycle u_lc (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot      (lc_boot),
        .adv_valid (lc_adv_valid),
        .adv_state (lc_adv_state),
        .lc        (lc),
        .bump      (bump)
    );

    dag_lfsr #(.W(RESP_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    dag_mixer #(.ROUNDS(ROUNDS)) u_mix (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mix_start),
        .seed  (chal_q),
        .key   (secret),
        .acc   (expect_q),
        .fin   (mix_fin)
    );

    assign enforced  = (lc == LC_PROD) || (lc == LC_USER);
    assign locked    = (fail_cnt >= FAIL_W'(MAX_FAILS));
    assign mix_start = (st == S_WAIT) && resp_valid && !bump;

    // Secret store: written only in development, never reset.
    always_ff @(posedge clk) begin
        if (prov_we && lc == LC_DEV)
            secret <= prov_secret;
    end

    // Exchange sequencer, unlock state and wrong-result counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            chal_q    <= '0;
            resp_q    <= '0;
            unlock    <= 1'b0;
            fail_cnt  <= '0;
            auth_done <= 1'b0;
            auth_ok   <= 1'b0;
        end else begin
            auth_done <= 1'b0;
            auth_ok   <= 1'b0;
            if (bump) begin
                st     <= S_IDLE;
                unlock <= 1'b0;
            end else begin
                case (st)
                    S_IDLE: if (dbg_req && enforced && !locked) begin
                        chal_q <= lfsr_q;
                        st     <= S_WAIT;
                    end
                    S_WAIT: if (resp_valid) begin
                        resp_q <= resp;
                        st     <= S_MIX;
                    end
                    S_MIX: if (mix_fin) begin
                        st        <= S_IDLE;
                        auth_done <= 1'b1;
                        auth_ok   <= (resp_q == expect_q);
                        unlock    <= (resp_q == expect_q);
                        fail_cnt  <= (resp_q == expect_q) ? '0 : fail_cnt + FAIL_W'(1);
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    assign lc_state   = lc;
    assign chal_valid = (st == S_WAIT);
    assign chal       = chal_q;
    assign chain_en   = (lc == LC_DEV) || (unlock && enforced);
endmodule

// File: rtl/dbg_auth_gate_chk.sv
// Property checker for dbg_auth_gate, attached by bind.
// Watches ports only; keeps a copy of the last challenge for freshness.
module dbg_auth_gate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  lc_state,
    input logic        chal_valid,
    input logic [31:0] chal,
    input logic        auth_done,
    input logic        auth_ok,
    input logic        chain_en
);
    logic [31:0] prev_chal;
    logic        have_prev;
    logic        cv_d;

    // Remember the most recent challenge presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_chal <= '0;
            have_prev <= 1'b0;
            cv_d      <= 1'b0;
        end else begin
            cv_d <= chal_valid;
            if (chal_valid && !cv_d) begin
                prev_chal <= chal;
                have_prev <= 1'b1;
            end
        end
    end

    p_fresh_chal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chal_valid && !cv_d && have_prev) |-> (chal != prev_chal));

    p_rise_needs_auth_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(chain_en) && lc_state != 2'd0) |-> auth_ok);

    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        auth_done |=> !auth_done);

    p_done_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        auth_done |-> !chal_valid);

    p_dev_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_state == 2'd0) |-> chain_en);

    p_eol_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lc_state == 2'd3) |-> (!chain_en && !chal_valid));

    p_lc_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lc_state >= $past(lc_state));

    p_change_locks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lc_state) |-> (!chain_en && !chal_valid));
endmodule

bind dbg_auth_gate dbg_auth_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lc_state   (lc_state),
    .chal_valid (chal_valid),
    .chal       (chal),
    .auth_done  (auth_done),
    .auth_ok    (auth_ok),
    .chain_en   (chain_en)
);

// File: tb/sim_dbg_auth_gate.sv
// Self-checking bench for dbg_auth_gate: seeded random exchanges plus
// directed lifecycle, provisioning and lockout cases.
module sim_dbg_auth_gate;
    localparam int ROUNDS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  lc_boot = 2'd1;
    logic        lc_adv_valid = 1'b0;
    logic [1:0]  lc_adv_state = 2'd0;
    logic [1:0]  lc_state;
    logic        prov_we = 1'b0;
    logic [63:0] prov_secret = '0;
    logic        dbg_req = 1'b0;
    logic        chal_valid;
    logic [31:0] chal;
    logic        resp_valid = 1'b0;
    logic [31:0] resp = '0;
    logic        auth_done;
    logic        auth_ok;
    logic        chain_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dbg_auth_gate #(.ROUNDS(ROUNDS)) u0 (.*);

    localparam logic [63:0] K1 = 64'h3C5A_96F0_0F69_A5C3;
    localparam logic [63:0] K2 = 64'hDEAD_0000_BEEF_1111;

    // Expected response per the round definition in the requirements.
    function automatic logic [31:0] model_resp(input logic [31:0] c, input logic [63:0] k);
        logic [31:0] x, kw, t;
        x = c;
        for (int i = 0; i < ROUNDS; i++) begin
            kw = (i % 2 == 1) ? k[63:32] : k[31:0];
            t  = x ^ kw;
            x  = {t[26:0], t[31:27]} + kw + 32'(i);
        end
        return x;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] boot);
        rst_n = 1'b0;
        lc_boot = boot;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic advance(input logic [1:0] s);
        lc_adv_valid = 1'b1;
        lc_adv_state = s;
        tick();
        lc_adv_valid = 1'b0;
    endtask

    task automatic request(output logic got, output logic [31:0] c);
        dbg_req = 1'b1;
        tick();
        dbg_req = 1'b0;
        got = chal_valid;
        c = chal;
    endtask

    // Send a response, time the result, check it against expectation.
    task automatic respond(input logic [31:0] r, input bit exp_ok, input string tag);
        int n;
        resp_valid = 1'b1;
        resp = r;
        tick();
        resp_valid = 1'b0;
        check(!chal_valid, {tag, " R5 challenge consumed"}, chal_valid, 0);
        n = 0;
        while (!auth_done && n < 40) begin
            tick();
            n++;
        end
        check(n == ROUNDS + 1, {tag, " R4 latency"}, n, ROUNDS + 1);
        check(auth_ok == exp_ok, {tag, " R3 auth_ok"}, auth_ok, exp_ok);
        check(chain_en == exp_ok, {tag, " R3/R12 chain_en"}, chain_en, exp_ok);
        tick();
        check(!auth_done, {tag, " R4 single pulse"}, auth_done, 0);
    endtask

    // One exchange expected to proceed, right or wrong.
    task automatic exchange(input bit right, input string tag);
        logic got;
        logic [31:0] c;
        request(got, c);
        check(got, {tag, " R2 challenge raised"}, got, 1);
        respond(right ? model_resp(c, K1) : ~model_resp(c, K1), right, tag);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic got;
        logic [31:0] c, last_c;
        bit have_last;
        int model_fails;
        void'($urandom(32'd1234));

        // Development: open without exchange, provision secret.
        do_reset(2'd0);
        check(lc_state == 2'd0, "R1 boot DEV lc_state", lc_state, 0);
        check(chain_en, "R7 DEV chains open", chain_en, 1);
        request(got, c);
        check(!got, "R7 DEV request ignored", got, 0);
        prov_we = 1'b1; prov_secret = K1; tick(); prov_we = 1'b0;
        advance(2'd1);
        check(lc_state == 2'd1, "R9 advance to PROD", lc_state, 1);
        check(!chain_en, "R10 advance closes chains", chain_en, 0);
        advance(2'd0);
        check(lc_state == 2'd1, "R9 backward ignored", lc_state, 1);
        advance(2'd1);
        check(lc_state == 2'd1, "R9 equal ignored", lc_state, 1);
        prov_we = 1'b1; prov_secret = K2; tick(); prov_we = 1'b0;
        exchange(1'b1, "R11 old secret still valid");

        // Reset in production.
        do_reset(2'd1);
        check(!chain_en && !chal_valid && !auth_done, "R1 reset closed", chain_en, 0);
        check(lc_state == 2'd1, "R1 boot PROD lc_state", lc_state, 1);
        resp_valid = 1'b1; resp = 32'h1; tick(); resp_valid = 1'b0;
        repeat (ROUNDS + 3) begin
            check(!auth_done, "R5 stray response ignored", auth_done, 0);
            tick();
        end

        // Seeded random exchanges with a lockout model.
        model_fails = 0;
        have_last = 1'b0;
        last_c = '0;
        for (int it = 0; it < 30; it++) begin
            bit wrong;
            request(got, c);
            if (model_fails >= 3) begin
                check(!got, "R6 locked request ignored", got, 0);
            end else begin
                check(got, "R2 random challenge raised", got, 1);
                if (have_last)
                    check(c != last_c, "R2 challenge fresh", c, ~last_c);
                last_c = c;
                have_last = 1'b1;
                wrong = ($urandom % 4) == 0;
                if (wrong) begin
                    respond(model_resp(c, K1) ^ (32'd1 << ($urandom % 32)), 1'b0, "R3 random wrong");
                    model_fails++;
                end else begin
                    respond(model_resp(c, K1), 1'b1, "R3 random right");
                    model_fails = 0;
                end
            end
            repeat ($urandom % 5) tick();
        end

        // Directed: one attempt per challenge, counter clear, lockout.
        do_reset(2'd1);
        exchange(1'b1, "R3 directed right");
        resp_valid = 1'b1; resp = 32'h0; tick(); resp_valid = 1'b0;
        repeat (ROUNDS + 3) begin
            check(!auth_done, "R5 second response ignored", auth_done, 0);
            tick();
        end
        check(chain_en, "R5 unlock kept", chain_en, 1);
        exchange(1'b0, "R12 wrong clears unlock");
        exchange(1'b0, "R6 miss 2");
        exchange(1'b1, "R6 hit clears count");
        exchange(1'b0, "R6 miss a");
        exchange(1'b0, "R6 miss b");
        exchange(1'b0, "R6 miss c");
        request(got, c);
        check(!got, "R6 lockout after three misses", got, 0);
        do_reset(2'd1);
        request(got, c);
        check(got, "R6 reset clears lockout", got, 1);
        respond(model_resp(c, K1), 1'b1, "R6 post-reset right");

        // Lifecycle changes: unlock clear, abort, end-of-life.
        advance(2'd2);
        check(lc_state == 2'd2 && !chain_en, "R10 USER clears unlock", chain_en, 0);
        request(got, c);
        check(got, "R2 USER challenge", got, 1);
        advance(2'd3);
        check(!chal_valid, "R10 advance aborts exchange", chal_valid, 0);
        check(lc_state == 2'd3 && !chain_en, "R8 EOL closed", chain_en, 0);
        request(got, c);
        check(!got, "R8 EOL request ignored", got, 0);
        advance(2'd1);
        check(lc_state == 2'd3, "R9 EOL is final", lc_state, 3);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule